// File: doc/BRIEF.md
# CAN Transmit Mailbox Abort Controller

This block keeps the 4-bit control code and the interrupt flag of every transmit mailbox in a CAN controller. It decides what happens when the CPU asks to withdraw a queued frame. The CPU writes a code into one mailbox. The transmit engine reports which mailbox, if any, is in flight, meaning it is either being sent or already copied into the serial transmit buffer. Strobes from the bus side report frame completion, lost arbitration, transmission errors and entry into freeze mode.

When the abort feature is enabled, writing the abort code to a mailbox that is not in flight withdraws that mailbox at once. If the mailbox is in flight, the write is held back and a per-mailbox pending bit records the request. A later bus event then settles the request. If arbitration is lost, an error occurs or freeze is entered, the frame is reported as aborted. If the frame completes, it is reported as sent. Each outcome sets the mailbox flag, and the interrupt request is the OR of all flags whose enable bit is set. When the feature is disabled, CPU writes land in the code field unchanged and no abort handling takes place.

The CPU writes and the bus strobes are single-cycle control pulses with no back-pressure, so no valid/ready handshake is used. Every code and flag update is registered and appears on the outputs one clock after the event. The interrupt request follows the flags combinationally.

Top module: `can_tx_abort_ctrl`

## Requirements
- R1: While reset is held, every code field reads 4'b1000 (inactive), every flag reads 0 and irq_o is 0.
- R2: With abort_en = 0, a CPU write stores wr_code into the addressed code field one cycle later, even for 4'b1001 or for an in-flight mailbox. Such a write sets no flag, and a later arb_lost, tx_err or freeze has no effect on that mailbox.
- R3: With abort_en = 1, writing 4'b1001 to a mailbox that is not in flight makes its code 4'b1001 and sets its flag one cycle later.
- R4: With abort_en = 1, writing 4'b1001 to the in-flight mailbox leaves its code unchanged and its flag clear, and records a pending abort.
- R5: A pending abort on the in-flight mailbox is resolved by arb_lost or tx_err. One cycle later the code is 4'b1001, the flag is set and the pending bit is clear. Without a pending abort, these strobes change nothing.
- R6: freeze resolves every pending abort, whether or not the mailbox is still in flight, in the same way as R5. Without a pending abort, freeze changes nothing.
- R7: tx_done on the in-flight mailbox sets its code to 4'b1000 and its flag one cycle later, and clears any pending abort. A later abort-resolving strobe then has no effect.
- R8: When tx_done and a resolving strobe (arb_lost, tx_err or freeze) hit the same mailbox in the same cycle, tx_done takes precedence.
- R9: With abort_en = 1, a write of any code other than 4'b1001 is ignored if the mailbox holds 4'b1100 (active transmit) or is in flight. Otherwise the write is stored.
- R10: A 1 on a flag_clr bit clears that flag. If the flag is set in the same cycle, the set takes precedence.
- R11: irq_o is 1 exactly when some mailbox has both its flag and its int_en bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_en | input | 1 | Enables abort handling |
| wr_en | input | 1 | CPU code write strobe |
| wr_idx | input | IDX_W | Mailbox addressed by the write |
| wr_code | input | 4 | Code being written |
| inflight_vld | input | 1 | A mailbox is transmitting or loaded in the serial buffer |
| inflight_idx | input | IDX_W | Index of that mailbox |
| tx_done | input | 1 | In-flight frame sent successfully |
| arb_lost | input | 1 | In-flight frame lost arbitration |
| tx_err | input | 1 | Error during the in-flight frame |
| freeze | input | 1 | Freeze mode entered |
| flag_clr | input | NUM_MB | Write-one-to-clear for the flags |
| int_en | input | NUM_MB | Per-mailbox interrupt enable |
| mb_code_o | output | 4*NUM_MB | Code fields, mailbox i at bits [4i+3:4i] |
| iflag_o | output | NUM_MB | Per-mailbox interrupt flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_MB = 4, so IDX_W is 2 and the highest index, 3, is reached on both the write path and the in-flight path. Four mailboxes are enough to hold a finished abort, a finished send and a live pending request side by side, which shows that each outcome stays local to its own mailbox. Same-cycle collisions, such as completion against lost arbitration or a flag set against its clear, are driven directly.

// File: rtl/can_abort_pkg.sv
package can_abort_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] mb_code_t;

  // Mailbox control codes used by this block
  localparam mb_code_t MB_TX_IDLE  = 4'b1000;
  localparam mb_code_t MB_TX_ABORT = 4'b1001;
  localparam mb_code_t MB_TX_SEND  = 4'b1100;

  function automatic logic code_is_active(input mb_code_t c);
    return c == MB_TX_SEND;
  endfunction
endpackage

// File: rtl/abort_evt_decode.sv
module abort_evt_decode #(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = 3
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              inflight_vld,
  input  logic [IDX_W-1:0]  inflight_idx,
  input  logic              tx_done,
  input  logic              arb_lost,
  input  logic              tx_err,
  output logic [NUM_MB-1:0] wr_hit,
  output logic [NUM_MB-1:0] fly_hit,
  output logic [NUM_MB-1:0] done_hit,
  output logic [NUM_MB-1:0] bus_abort_hit
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_dec
    assign wr_hit[i]        = wr_en && (wr_idx == IDX_W'(i));
    assign fly_hit[i]       = inflight_vld && (inflight_idx == IDX_W'(i));
    assign done_hit[i]      = fly_hit[i] && tx_done;
    assign bus_abort_hit[i] = fly_hit[i] && (arb_lost || tx_err);
  end
endmodule

// File: rtl/abort_mb_slot.sv
module abort_mb_slot
  import can_abort_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     abort_en,
  input  logic     wr_hit,
  input  mb_code_t wr_code,
  input  logic     in_flight,
  input  logic     done_hit,
  input  logic     bus_abort_hit,
  input  logic     freeze,
  input  logic     flag_clr,
  output mb_code_t code_o,
  output logic     flag_o
);
  mb_code_t code_q, code_d;
  logic     pend_q, pend_d;
  logic     flag_q, flag_d;
  logic     set_flag;
  logic     abort_wr;
  logic     resolve;

  assign abort_wr = wr_hit && abort_en && (wr_code == MB_TX_ABORT);
  assign resolve  = pend_q && (bus_abort_hit || freeze);

  always_comb begin
    code_d   = code_q;
    pend_d   = pend_q;
    set_flag = 1'b0;
    if (done_hit) begin
      code_d   = MB_TX_IDLE;
      pend_d   = 1'b0;
      set_flag = 1'b1;
    end else if (resolve) begin
      code_d   = MB_TX_ABORT;
      pend_d   = 1'b0;
      set_flag = 1'b1;
    end else if (wr_hit) begin
      if (!abort_en) begin
        code_d = wr_code;
      end else if (abort_wr) begin
        if (in_flight) begin
          pend_d = 1'b1;
        end else begin
          code_d   = MB_TX_ABORT;
          pend_d   = 1'b0;
          set_flag = 1'b1;
        end
      end else if (!(in_flight || code_is_active(code_q))) begin
        code_d = wr_code;
      end
    end
    flag_d = set_flag || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MB_TX_IDLE;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      code_q <= code_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign code_o = code_q;
  assign flag_o = flag_q;

  // R7 / R8: completion always lands as inactive with flag set
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> (code_q == MB_TX_IDLE) && flag_q && !pend_q);

  // R4: abort on in-flight mailbox is held, not applied
  p_abort_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_wr && in_flight && !done_hit && !resolve) |=> pend_q && !flag_q || pend_q && $past(flag_q));

  // R5: bus event resolves a pending abort as aborted
  p_bus_resolve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bus_abort_hit && !done_hit) |=> (code_q == MB_TX_ABORT) && flag_q && !pend_q);

  // R6: freeze resolves a pending abort as aborted
  p_freeze_resolve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && freeze && !done_hit) |=> (code_q == MB_TX_ABORT) && flag_q && !pend_q);

  // R2: with the feature off, a write lands unchanged
  p_legacy_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_en && wr_hit && !done_hit && !resolve) |=> code_q == $past(wr_code));

  // R10: a clear with no competing set empties the flag
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done_hit && !wr_hit && !resolve) |=> !flag_q);
endmodule

// File: rtl/abort_irq_gen.sv
module abort_irq_gen #(
  parameter int NUM_MB = 8
) (
  input  logic [NUM_MB-1:0] flag_i,
  input  logic [NUM_MB-1:0] en_i,
  output logic              irq_o
);
  assign irq_o = |(flag_i & en_i);
endmodule

// File: rtl/can_tx_abort_ctrl.sv
module can_tx_abort_ctrl
  import can_abort_pkg::*;
#(
  parameter int NUM_MB = 8,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     abort_en,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic                     inflight_vld,
  input  logic [IDX_W-1:0]         inflight_idx,
  input  logic                     tx_done,
  input  logic                     arb_lost,
  input  logic                     tx_err,
  input  logic                     freeze,
  input  logic [NUM_MB-1:0]        flag_clr,
  input  logic [NUM_MB-1:0]        int_en,
  output logic [NUM_MB*CODE_W-1:0] mb_code_o,
  output logic [NUM_MB-1:0]        iflag_o,
  output logic                     irq_o
);
  logic [NUM_MB-1:0] wr_hit, fly_hit, done_hit, bus_abort_hit;

  abort_evt_decode #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_dec (
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .inflight_vld  (inflight_vld),
    .inflight_idx  (inflight_idx),
    .tx_done       (tx_done),
    .arb_lost      (arb_lost),
    .tx_err        (tx_err),
    .wr_hit        (wr_hit),
    .fly_hit       (fly_hit),
    .done_hit      (done_hit),
    .bus_abort_hit (bus_abort_hit)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    abort_mb_slot u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .abort_en      (abort_en),
      .wr_hit        (wr_hit[i]),
      .wr_code       (wr_code),
      .in_flight     (fly_hit[i]),
      .done_hit      (done_hit[i]),
      .bus_abort_hit (bus_abort_hit[i]),
      .freeze        (freeze),
      .flag_clr      (flag_clr[i]),
      .code_o        (mb_code_o[i*CODE_W +: CODE_W]),
      .flag_o        (iflag_o[i])
    );
  end

  abort_irq_gen #(.NUM_MB(NUM_MB)) u_irq (
    .flag_i (iflag_o),
    .en_i   (int_en),
    .irq_o  (irq_o)
  );

  // R1: flags are empty right after a reset cycle
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (iflag_o == '0));

  // R11: no request without an enabled flag
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o |-> $countones(iflag_o & int_en) > 0));
endmodule

// File: tb/can_tx_abort_ctrl_test.sv
module can_tx_abort_ctrl_test;
  localparam int NMB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_idx = '0, inflight_idx = '0;
  logic [3:0] wr_code = '0;
  logic       inflight_vld = 1'b0, tx_done = 1'b0, arb_lost = 1'b0, tx_err = 1'b0, freeze = 1'b0;
  logic [NMB-1:0] flag_clr = '0, int_en = '0;
  logic [NMB*4-1:0] mb_code_o;
  logic [NMB-1:0]   iflag_o;
  logic             irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_tx_abort_ctrl #(.NUM_MB(NMB)) uut (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .inflight_vld(inflight_vld), .inflight_idx(inflight_idx),
    .tx_done(tx_done), .arb_lost(arb_lost), .tx_err(tx_err), .freeze(freeze),
    .flag_clr(flag_clr), .int_en(int_en), .mb_code_o(mb_code_o), .iflag_o(iflag_o),
    .irq_o(irq_o)
  );

  // {abort_en, wr_en, wr_idx, wr_code, inflight_vld, inflight_idx,
  //  {done,arb,err,frz}, flag_clr, check_idx, exp_code, exp_flag, req}
  localparam int NV = 21;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1,1'b1,2'd0,4'hC,1'b0,2'd0,4'b0000,4'h0,2'd0,4'hC,1'b0,4'd9},  // R9 load idle mb0
    {1'b1,1'b1,2'd1,4'hC,1'b0,2'd0,4'b0000,4'h0,2'd1,4'hC,1'b0,4'd9},  // R9
    {1'b1,1'b1,2'd2,4'hC,1'b0,2'd0,4'b0000,4'h0,2'd2,4'hC,1'b0,4'd9},  // R9
    {1'b1,1'b1,2'd3,4'hC,1'b0,2'd0,4'b0000,4'h0,2'd3,4'hC,1'b0,4'd9},  // R9 top index
    {1'b1,1'b1,2'd0,4'h8,1'b0,2'd0,4'b0000,4'h0,2'd0,4'hC,1'b0,4'd9},  // R9 blocked on active
    {1'b1,1'b1,2'd0,4'h9,1'b0,2'd0,4'b0000,4'h0,2'd0,4'h9,1'b1,4'd3},  // R3 immediate abort
    {1'b1,1'b0,2'd0,4'h0,1'b0,2'd0,4'b0000,4'h1,2'd0,4'h9,1'b0,4'd10}, // R10 w1c
    {1'b1,1'b1,2'd1,4'h9,1'b1,2'd1,4'b0000,4'h0,2'd1,4'hC,1'b0,4'd4},  // R4 held
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd1,4'b0100,4'h0,2'd1,4'h9,1'b1,4'd5},  // R5 arb lost
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd1,4'b0100,4'h2,2'd1,4'h9,1'b0,4'd5},  // R5 no pending left
    {1'b1,1'b1,2'd2,4'h9,1'b1,2'd2,4'b0000,4'h0,2'd2,4'hC,1'b0,4'd4},  // R4
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd2,4'b1000,4'h0,2'd2,4'h8,1'b1,4'd7},  // R7 sent anyway
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd2,4'b0010,4'h4,2'd2,4'h8,1'b0,4'd7},  // R7 pending gone
    {1'b1,1'b1,2'd3,4'h9,1'b1,2'd3,4'b0000,4'h0,2'd3,4'hC,1'b0,4'd4},  // R4
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd3,4'b1100,4'h0,2'd3,4'h8,1'b1,4'd8},  // R8 done beats arb
    {1'b1,1'b1,2'd2,4'hC,1'b0,2'd0,4'b0000,4'h0,2'd2,4'hC,1'b0,4'd9},  // R9 reload mb2
    {1'b1,1'b1,2'd2,4'h8,1'b1,2'd2,4'b0000,4'h0,2'd2,4'hC,1'b0,4'd9},  // R9 blocked in flight
    {1'b1,1'b0,2'd0,4'h0,1'b1,2'd2,4'b0010,4'h0,2'd2,4'hC,1'b0,4'd5},  // R5 err w/o pending
    {1'b1,1'b1,2'd2,4'h9,1'b1,2'd2,4'b0000,4'h0,2'd2,4'hC,1'b0,4'd4},  // R4
    {1'b1,1'b0,2'd0,4'h0,1'b0,2'd0,4'b0001,4'h0,2'd2,4'h9,1'b1,4'd6},  // R6 freeze
    {1'b1,1'b0,2'd0,4'h0,1'b0,2'd0,4'b0001,4'h4,2'd2,4'h9,1'b0,4'd6}   // R6 freeze w/o pending
  };

  task automatic check(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic wr, input logic [1:0] wi, input logic [3:0] wc,
                       input logic fv, input logic [1:0] fi, input logic [3:0] ev, input logic [3:0] clr);
    abort_en = en; wr_en = wr; wr_idx = wi; wr_code = wc;
    inflight_vld = fv; inflight_idx = fi;
    {tx_done, arb_lost, tx_err, freeze} = ev;
    flag_clr = clr;
  endtask

  task automatic step_check(input int req, input logic [1:0] idx, input logic [3:0] ecode, input logic eflag);
    @(negedge clk);
    check(req, $sformatf("code mb%0d", idx), mb_code_o[idx*4 +: 4], ecode);
    check(req, $sformatf("flag mb%0d", idx), {3'b0, iflag_o[idx]}, {3'b0, eflag});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int m = 0; m < NMB; m++) check(1, "reset code", mb_code_o[m*4 +: 4], 4'h8);
    check(1, "reset flags", iflag_o, 4'h0);
    check(1, "reset irq", {3'b0, irq_o}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [29:0] v;
      v = VEC[k];
      drive(v[29], v[28], v[27:26], v[25:22], v[21], v[20:19], v[18:15], v[14:11]);
      step_check(int'(v[3:0]), v[10:9], v[8:5], v[4]);
    end
    drive(1'b1, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0, 4'b0000, 4'h0);
    @(negedge clk);

    // R11 irq gating: only mb3 holds a flag now
    int_en = 4'b0000; #1;
    check(11, "irq none enabled", {3'b0, irq_o}, 4'h0);
    int_en = 4'b1000; #1;
    check(11, "irq mb3 enabled", {3'b0, irq_o}, 4'h1);
    int_en = 4'b0111; #1;
    check(11, "irq other enabled", {3'b0, irq_o}, 4'h0);

    // R10 set wins over clear in the same cycle (mb1 holds 1001, flag 0)
    drive(1'b1, 1'b1, 2'd1, 4'hC, 1'b0, 2'd0, 4'b0000, 4'h0);
    step_check(9, 2'd1, 4'hC, 1'b0);
    drive(1'b1, 1'b1, 2'd1, 4'h9, 1'b0, 2'd0, 4'b0000, 4'h2);
    step_check(10, 2'd1, 4'h9, 1'b1);
    #1 check(11, "irq from mb1", {3'b0, irq_o}, 4'h1);

    // R2 feature off: writes land as-is on an in-flight mailbox, no pending
    drive(1'b0, 1'b1, 2'd0, 4'hC, 1'b1, 2'd0, 4'b0000, 4'h0);
    step_check(2, 2'd0, 4'hC, 1'b0);
    drive(1'b0, 1'b1, 2'd0, 4'h9, 1'b1, 2'd0, 4'b0000, 4'h0);
    step_check(2, 2'd0, 4'h9, 1'b0);
    drive(1'b0, 1'b0, 2'd0, 4'h0, 1'b1, 2'd0, 4'b0100, 4'h0);
    step_check(2, 2'd0, 4'h9, 1'b0);
    drive(1'b1, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0, 4'b0001, 4'h0);
    step_check(2, 2'd0, 4'h9, 1'b0);
    drive(1'b0, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0, 4'b0000, 4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule